// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit processor core and a memory that is one word wide. On the store side it takes a byte address, an access size and a register value. It produces one write enable per byte lane and a write word whose data sits in the lanes the access touches. On the load side it takes the same address and size, a flag that selects signed or unsigned extension, and the raw word read from memory. It returns a full 32-bit register value.

Lanes are numbered big-endian. The byte at the lowest address of a word occupies bits [31:24], and the byte at offset 3 occupies bits [7:0]. Every access must be aligned to its own size: words need an address that is a multiple of four, and halfwords need an even address. The block reports any access that breaks this rule. It holds no state, so every output follows its inputs within the same cycle. Address arithmetic, the memory array and exception handling belong to the surrounding logic.

Top module: `bigend_lane_align`

## Requirements
- R1: For an aligned byte store at offset k = addrIn[1:0], byteEn has exactly one bit set, at bit (3-k). Bit 3 of byteEn covers bits [31:24] of the memory word.
- R2: An aligned halfword store at offset 0 drives byteEn = 4'b1100, and one at offset 2 drives 4'b0011. A word store at offset 0 drives 4'b1111.
- R3: memWdata depends only on the size code (00 byte, 01 halfword, 10 word, 11 reserved). For a byte it carries regData[7:0] in all four lanes. For a halfword it carries regData[15:0] in both halves. For a word or the reserved code it carries regData unchanged.
- R4: misAlign is 1 in the following cases and 0 otherwise: a halfword with addrIn[0]=1, a word with addrIn[1:0]≠0, or the reserved size code 11. It behaves the same for loads and stores.
- R5: byteEn is 4'b0000 whenever isStore=0 or misAlign=1.
- R6: An aligned word access returns memRdata unchanged on ldData.
- R7: An aligned byte access at offset k takes memRdata bits [31-8k:24-8k]. When unsignedLd=1 it zero-extends that byte to 32 bits, and when unsignedLd=0 it sign-extends it.
- R8: An aligned halfword access takes memRdata[31:16] at offset 0 and memRdata[15:0] at offset 2. It zero-extends or sign-extends the halfword according to unsignedLd, as in R7.
- R9: ldData is all zeros whenever misAlign=1.
- R10: Address bits above bit 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addrIn | input | 32 | Byte address of the access |
| accSize | input | 2 | Size code: 00 byte, 01 halfword, 10 word, 11 reserved |
| isStore | input | 1 | 1 for a store, 0 for a load |
| unsignedLd | input | 1 | 1 selects zero extension of byte and halfword loads |
| regData | input | 32 | Source register value for stores |
| memRdata | input | 32 | Raw word read from memory |
| byteEn | output | 4 | Per-lane write enables, bit 3 for bits [31:24] |
| memWdata | output | 32 | Write word with the store data in its lanes |
| ldData | output | 32 | Extended load result |
| misAlign | output | 1 | Access not aligned to its size, or reserved size |

## Verification
Assertions evaluated on every input change check the following properties:
- a byte store raises exactly one enable and a word store raises all four;
- a misaligned access silences every enable and returns zero;
- an unsigned byte load has zero upper bits;
- a signed halfword load has upper bits that copy bit 15.

These assertions cannot show that the chosen lane is the correct one for the offset, or that the correct bytes were steered and extracted. Only the bench's comparison against reference functions shows that, across directed offsets, sign-bit patterns and random vectors. The same holds for the insensitivity to upper address bits, which needs two scenarios compared with each other.

// File: rtl/bigend_align_pkg.sv
package bigend_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic pickByte;
    logic pickHalf;
    logic pickWord;
    logic extSign;
    logic fault;
    logic wrEn;
  } alignStrobe_t;

endpackage

// File: rtl/align_ctrl.sv
module align_ctrl
  import bigend_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] addrLow,
  input  logic [1:0]       accSize,
  input  logic             isStore,
  input  logic             unsignedLd,
  output alignStrobe_t     strobe,
  output logic [LANES-1:0] laneMask
);

  localparam logic [LANES-1:0] TOP_BYTE = LANES'(1) << (LANES - 1);
  localparam logic [LANES-1:0] TOP_HALF = LANES'(3) << (LANES - 2);

  always_comb begin
    strobe   = '0;
    laneMask = '0;
    case (accSize_e'(accSize))
      SZ_BYTE: begin
        strobe.pickByte = 1'b1;
        laneMask        = TOP_BYTE >> addrLow;
      end
      SZ_HALF: begin
        strobe.pickHalf = 1'b1;
        strobe.fault    = addrLow[0];
        laneMask        = TOP_HALF >> addrLow;
      end
      SZ_WORD: begin
        strobe.pickWord = 1'b1;
        strobe.fault    = |addrLow;
        laneMask        = '1;
      end
      default: begin
        strobe.pickWord = 1'b1;
        strobe.fault    = 1'b1;
      end
    endcase
    strobe.extSign = ~unsignedLd;
    strobe.wrEn    = isStore & ~strobe.fault;
  end

endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import bigend_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  alignStrobe_t      strobe,
  input  logic [LANES-1:0]  laneMask,
  input  logic [OFF_W-1:0]  laneOff,
  input  logic [DATA_W-1:0] regData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] ldData
);

  localparam int SH_W = OFF_W + 3;

  // Store steering: replicate the narrow value into every lane
  for (genvar g = 0; g < LANES; g++) begin : g_wrLane
    always_comb begin
      if (strobe.pickByte)
        memWdata[8*g +: 8] = regData[7:0];
      else if (strobe.pickHalf)
        memWdata[8*g +: 8] = regData[8*(g % 2) +: 8];
      else
        memWdata[8*g +: 8] = regData[8*g +: 8];
    end
  end

  assign byteEn = strobe.wrEn ? laneMask : '0;

  // Load extraction: move the addressed lane to the top, then extend
  logic [DATA_W-1:0] aligned;
  logic [7:0]        pickedByte;
  logic [15:0]       pickedHalf;

  always_comb begin
    aligned    = memRdata << SH_W'({laneOff, 3'b000});
    pickedByte = aligned[DATA_W-1 -: 8];
    pickedHalf = aligned[DATA_W-1 -: 16];
    if (strobe.fault)
      ldData = '0;
    else if (strobe.pickByte)
      ldData = {{(DATA_W-8){strobe.extSign & pickedByte[7]}}, pickedByte};
    else if (strobe.pickHalf)
      ldData = {{(DATA_W-16){strobe.extSign & pickedHalf[15]}}, pickedHalf};
    else
      ldData = memRdata;
  end

endmodule

// File: rtl/bigend_lane_align.sv
module bigend_lane_align
  import bigend_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [1:0]          accSize,
  input  logic                isStore,
  input  logic                unsignedLd,
  input  logic [DATA_W-1:0]   regData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W/8-1:0] byteEn,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   ldData,
  output logic                misAlign
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  alignStrobe_t     strobe;
  logic [LANES-1:0] laneMask;
  logic             unusedAddrHi;

  assign unusedAddrHi = ^addrIn[ADDR_W-1:OFF_W];

  align_ctrl #(.LANES(LANES), .OFF_W(OFF_W)) ctrl_i (
    .addrLow    (addrIn[OFF_W-1:0]),
    .accSize    (accSize),
    .isStore    (isStore),
    .unsignedLd (unsignedLd),
    .strobe     (strobe),
    .laneMask   (laneMask)
  );

  align_datapath #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) dp_i (
    .strobe   (strobe),
    .laneMask (laneMask),
    .laneOff  (addrIn[OFF_W-1:0]),
    .regData  (regData),
    .memRdata (memRdata),
    .byteEn   (byteEn),
    .memWdata (memWdata),
    .ldData   (ldData)
  );

  assign misAlign = strobe.fault;

  always_comb begin
    // R1
    if (strobe.wrEn && strobe.pickByte) begin
      byte_onehot_chk: assert ($onehot(byteEn)) else $error("byte store enable not one-hot");
    end
    // R2
    if (strobe.wrEn && strobe.pickWord) begin
      word_all_lanes_chk: assert (&byteEn) else $error("word store missing lanes");
    end
    // R5
    if (misAlign) begin
      quiet_lanes_chk: assert (byteEn == '0) else $error("enables active on fault");
    end
    // R9
    if (misAlign) begin
      zero_load_chk: assert (ldData == '0) else $error("load data nonzero on fault");
    end
    // R7
    if (!misAlign && strobe.pickByte && !strobe.extSign) begin
      zext_byte_chk: assert (ldData[DATA_W-1:8] == '0) else $error("unsigned byte upper bits set");
    end
    // R8
    if (!misAlign && strobe.pickHalf && strobe.extSign) begin
      sext_half_chk: assert (ldData[DATA_W-1:16] == {(DATA_W-16){ldData[15]}})
        else $error("signed half extension wrong");
    end
  end

endmodule

// File: tb/bigend_lane_align_tb.sv
module bigend_lane_align_tb_top;

  logic        clk = 1'b0;
  logic [31:0] addrIn;
  logic [1:0]  accSize;
  logic        isStore;
  logic        unsignedLd;
  logic [31:0] regData;
  logic [31:0] memRdata;
  logic [3:0]  byteEn;
  logic [31:0] memWdata;
  logic [31:0] ldData;
  logic        misAlign;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bigend_lane_align dut_i (
    .addrIn(addrIn), .accSize(accSize), .isStore(isStore), .unsignedLd(unsignedLd),
    .regData(regData), .memRdata(memRdata), .byteEn(byteEn), .memWdata(memWdata),
    .ldData(ldData), .misAlign(misAlign)
  );

  function automatic logic refBad(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'b00:   return 1'b0;
      2'b01:   return off[0];
      2'b10:   return off != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] refEn(input logic [1:0] off, input logic [1:0] sz, input logic st);
    if (!st || refBad(off, sz)) return 4'b0000;
    case (sz)
      2'b00:   return 4'b1000 >> off;
      2'b01:   return (off == 2'b00) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] refWd(input logic [1:0] sz, input logic [31:0] rv);
    case (sz)
      2'b00:   return {4{rv[7:0]}};
      2'b01:   return {2{rv[15:0]}};
      default: return rv;
    endcase
  endfunction

  function automatic logic [31:0] refLd(input logic [1:0] off, input logic [1:0] sz,
                                        input logic us, input logic [31:0] md);
    logic [7:0]  b;
    logic [15:0] h;
    if (refBad(off, sz)) return 32'h0;
    case (sz)
      2'b00: begin
        b = md[31 - 8*off -: 8];
        return {{24{~us & b[7]}}, b};
      end
      2'b01: begin
        h = (off == 2'b00) ? md[31:16] : md[15:0];
        return {{16{~us & h[15]}}, h};
      end
      default: return md;
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [1:0] sz, input logic st,
                       input logic us, input logic [31:0] rv, input logic [31:0] md);
    @(negedge clk);
    addrIn = a; accSize = sz; isStore = st; unsignedLd = us; regData = rv; memRdata = md;
    #5;
  endtask

  task automatic checkAll();
    logic [1:0]  off;
    logic [3:0]  eEn;
    logic [31:0] eWd;
    logic [31:0] eLd;
    logic        eBad;
    string       enTag;
    string       ldTag;
    off  = addrIn[1:0];
    eBad = refBad(off, accSize);
    eEn  = refEn(off, accSize, isStore);
    eWd  = refWd(accSize, regData);
    eLd  = refLd(off, accSize, unsignedLd, memRdata);
    enTag = (eBad || !isStore) ? "R5" : (accSize == 2'b00) ? "R1" : "R2";
    ldTag = eBad ? "R9" : (accSize == 2'b10) ? "R6" : (accSize == 2'b00) ? "R7" : "R8";
    checks += 4;
    if (misAlign !== eBad) begin
      errors++; $display("FAIL R4 misAlign=%0b exp=%0b", misAlign, eBad);
    end
    if (byteEn !== eEn) begin
      errors++; $display("FAIL %s byteEn=%b exp=%b", enTag, byteEn, eEn);
    end
    if (memWdata !== eWd) begin
      errors++; $display("FAIL R3 memWdata=%h exp=%h", memWdata, eWd);
    end
    if (ldData !== eLd) begin
      errors++; $display("FAIL %s ldData=%h exp=%h", ldTag, ldData, eLd);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0]  saveEn;
    logic [31:0] saveWd;
    logic [31:0] saveLd;
    logic        saveBad;
    addrIn = '0; accSize = '0; isStore = 0; unsignedLd = 0; regData = '0; memRdata = '0;
    repeat (2) @(posedge clk);

    // Idle state: byte load of an all-zero word, no enables (R5, R7)
    drive(32'h0, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    checkAll();

    // R1: byte stores at every offset
    for (int k = 0; k < 4; k++) begin
      drive(32'h100 + k, 2'b00, 1'b1, 1'b0, 32'hCAFE_BEA5, 32'h0);
      checkAll();
    end
    // R2: halfword and word stores
    drive(32'h200, 2'b01, 1'b1, 1'b0, 32'h1234_ABCD, 32'h0); checkAll();
    drive(32'h202, 2'b01, 1'b1, 1'b0, 32'h1234_ABCD, 32'h0); checkAll();
    drive(32'h204, 2'b10, 1'b1, 1'b0, 32'h89AB_CDEF, 32'h0); checkAll();
    // R7: byte loads with sign-bit set and clear, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      drive(32'h300 + k, 2'b00, 1'b0, 1'b0, 32'h0, 32'h80_7F_FF_01); checkAll();
      drive(32'h300 + k, 2'b00, 1'b0, 1'b1, 32'h0, 32'h80_7F_FF_01); checkAll();
    end
    // R8: halfword loads
    drive(32'h400, 2'b01, 1'b0, 1'b0, 32'h0, 32'h8001_7FFE); checkAll();
    drive(32'h402, 2'b01, 1'b0, 1'b0, 32'h0, 32'h7FFE_8001); checkAll();
    drive(32'h402, 2'b01, 1'b0, 1'b1, 32'h0, 32'h7FFE_8001); checkAll();
    // R6: word load
    drive(32'h500, 2'b10, 1'b0, 1'b0, 32'h0, 32'hDEAD_BEEF); checkAll();
    // R4, R5, R9: misaligned and reserved size, both directions
    drive(32'h601, 2'b01, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); checkAll();
    drive(32'h603, 2'b01, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); checkAll();
    for (int k = 1; k < 4; k++) begin
      drive(32'h700 + k, 2'b10, 1'b1, 1'b0, 32'h5555_AAAA, 32'hFFFF_FFFF); checkAll();
    end
    drive(32'h800, 2'b11, 1'b1, 1'b0, 32'h5555_AAAA, 32'hFFFF_FFFF); checkAll();
    drive(32'h800, 2'b11, 1'b0, 1'b1, 32'h5555_AAAA, 32'hFFFF_FFFF); checkAll();

    // R10: upper address bits do not change the outputs
    drive(32'h0000_0002, 2'b01, 1'b1, 1'b0, 32'h0BAD_F00D, 32'h8765_4321);
    saveEn = byteEn; saveWd = memWdata; saveLd = ldData; saveBad = misAlign;
    drive(32'hFFFF_FFFE, 2'b01, 1'b1, 1'b0, 32'h0BAD_F00D, 32'h8765_4321);
    checks++;
    if ({byteEn, memWdata, ldData, misAlign} !== {saveEn, saveWd, saveLd, saveBad}) begin
      errors++;
      $display("FAIL R10 outputs=%h exp=%h", {byteEn, memWdata, ldData, misAlign},
               {saveEn, saveWd, saveLd, saveBad});
    end

    // Constrained random mix, biased toward aligned accesses
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      a  = $urandom;
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin
        if (sz == 2'b01) a[0] = 1'b0;
        if (sz == 2'b10) a[1:0] = 2'b00;
      end
      drive(a, sz, 1'($urandom), 1'($urandom), $urandom, $urandom);
      checkAll();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule